// File: doc/BRIEF.md
# Range-Invalidating Translation Cache

A small, fully associative cache of address translations. Every entry holds a valid flag, a virtual page tag at 4 KB resolution, the index of the translation regime it belongs to, and a physical page number. A lookup port returns a hit and the physical page in the same cycle. A fill port writes new translations into slots chosen round-robin.

The block also takes a range-invalidate command: one 64-bit operand and a bitmap of target regimes. The operand encodes a granule, a scale, a count and a base. The block turns these fields into a byte range of the form [low, high). If the encoded granule is not the granule currently configured, the range is empty. The block then visits the entries one per cycle. It clears each valid entry whose page address lies inside the range and whose regime has its bit set in the bitmap. While the walk runs, lookups report a miss, and fills and further commands are dropped.

Top module: `range_tlb`

## Requirements
- R1: After reset, every entry is invalid, `busy` and `done` are low, and every lookup misses.
- R2: A fill writes the next slot in round-robin order, starting from slot 0. A lookup hits only when a valid entry has the same tag (`lk_va[63:12]`) and the same regime index. It then returns that entry's physical page, taking the lowest-numbered slot if several entries match.
- R3: Operand bits [47:46] give the granule: 1 is 4 KB, 2 is 16 KB, 3 is 64 KB, and 0 is invalid. `cfg_gran` uses 0 for 4 KB, 1 for 16 KB, 2 for 64 KB, and 3 is reserved. A command whose granule is invalid or differs from `cfg_gran` clears no entry.
- R4: SCALE is taken from operand bits [45:44] and NUM from bits [43:39]. The range length in bytes is (NUM+1) << (5·SCALE + 1 + P), where P is 12, 14 or 16 for the three granules.
- R5: The base is operand bits [36:0], sign-extended from bit 36 to 64 bits and then shifted left by P.
- R6: When `cfg_ds` is high, the base is shifted left by 16 whatever the granule.
- R7: An entry is in range when low ≤ page address < low + length. The page address is the tag followed by 12 zero bits, and the comparison is unsigned on 65 bits. Entries one page below the base, or at the first page past the end, stay valid.
- R8: Only entries whose regime index has its bit set in `inv_regimes` are cleared. Several bits may be set at once.
- R9: An accepted command raises `busy` on the next edge. `busy` stays high for exactly ENTRIES cycles. `done` pulses for one cycle as `busy` falls. Fills and commands presented while `busy` is high are ignored.
- R10: While `busy` is high, `lk_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gran | input | 2 | Configured granule (0 4 KB, 1 16 KB, 2 64 KB) |
| cfg_ds | input | 1 | Wide-address mode: base always shifted by 16 |
| lk_va | input | 64 | Lookup virtual address |
| lk_regime | input | 2 | Lookup regime index |
| lk_hit | output | 1 | Lookup hit |
| lk_pa_page | output | 40 | Physical page of the hitting entry |
| fill_en | input | 1 | Write a translation |
| fill_va_page | input | 52 | Virtual page tag to write |
| fill_regime | input | 2 | Regime index to write |
| fill_pa_page | input | 40 | Physical page to write |
| inv_req | input | 1 | Start a range invalidation |
| inv_operand | input | 64 | Encoded range operand |
| inv_regimes | input | 4 | Bitmap of target regimes |
| busy | output | 1 | Invalidation walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The assertions check the walk's handshake on every cycle. An accepted command must raise `busy`, the walk must last exactly ENTRIES cycles, `done` must be a single pulse that coincides with `busy` falling, and no hit may appear during a walk. Only the bench scenarios can show which entries a command actually clears. That covers the decoding of granule, scale, count and sign-extended base, the wide-address shift, the exact edges of the range, regime filtering, and the fact that a granule mismatch leaves every entry intact. The bench compares lookups of every slot against a reference model after each command.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;
    localparam int VA_W     = 64;
    localparam int PG_LSB   = 12;
    localparam int TAG_W    = VA_W - PG_LSB;
    localparam int SPAN_W   = VA_W + 1;

    typedef enum logic [1:0] {
        GR_4K   = 2'd0,
        GR_16K  = 2'd1,
        GR_64K  = 2'd2,
        GR_RSVD = 2'd3
    } gran_e;

    typedef struct packed {
        logic [SPAN_W-1:0] lo;
        logic [SPAN_W-1:0] hi;
    } span_t;
endpackage

// File: rtl/range_tlb_decode.sv
module range_tlb_decode
    import range_tlb_pkg::*;
(
    input  logic [63:0] operand,
    input  logic [1:0]  cfg_gran,
    input  logic        cfg_ds,
    output span_t       span
);
    logic [1:0]        code;
    logic [1:0]        scale;
    logic [4:0]        num;
    logic              ok;
    logic [4:0]        pshift;
    logic [5:0]        len_sh;
    logic [4:0]        base_sh;
    logic [SPAN_W-1:0] len;
    logic [VA_W-1:0]   base_raw;

    always_comb begin
        code   = operand[47:46];
        scale  = operand[45:44];
        num    = operand[43:39];
        ok     = 1'b0;
        pshift = 5'd12;
        case (code)
            2'd1: begin pshift = 5'd12; ok = (cfg_gran == GR_4K);  end
            2'd2: begin pshift = 5'd14; ok = (cfg_gran == GR_16K); end
            2'd3: begin pshift = 5'd16; ok = (cfg_gran == GR_64K); end
            default: begin pshift = 5'd12; ok = 1'b0; end
        endcase
        len_sh   = 6'(5 * scale) + 6'd1 + 6'(pshift);
        len      = ok ? ((SPAN_W'(num) + SPAN_W'(1)) << len_sh) : '0;
        base_raw = {{(VA_W-37){operand[36]}}, operand[36:0]};
        base_sh  = cfg_ds ? 5'd16 : pshift;
        span.lo  = {1'b0, base_raw << base_sh};
        span.hi  = span.lo + len;
    end
endmodule

// File: rtl/range_tlb_probe.sv
module range_tlb_probe
    import range_tlb_pkg::*;
#(
    parameter int RID_W = 2
) (
    input  logic             vld,
    input  logic [TAG_W-1:0] tag,
    input  logic [RID_W-1:0] rid,
    input  logic [TAG_W-1:0] q_tag,
    input  logic [RID_W-1:0] q_rid,
    output logic             hit
);
    assign hit = vld && (tag == q_tag) && (rid == q_rid);
endmodule

// File: rtl/range_tlb.sv
module range_tlb
    import range_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int REGIMES = 4,
    parameter int PA_W    = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_gran,
    input  logic                     cfg_ds,
    input  logic [VA_W-1:0]          lk_va,
    input  logic [$clog2(REGIMES)-1:0] lk_regime,
    output logic                     lk_hit,
    output logic [PA_W-1:0]          lk_pa_page,
    input  logic                     fill_en,
    input  logic [TAG_W-1:0]         fill_va_page,
    input  logic [$clog2(REGIMES)-1:0] fill_regime,
    input  logic [PA_W-1:0]          fill_pa_page,
    input  logic                     inv_req,
    input  logic [63:0]              inv_operand,
    input  logic [REGIMES-1:0]       inv_regimes,
    output logic                     busy,
    output logic                     done
);
    localparam int RID_W = $clog2(REGIMES);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][RID_W-1:0]  rid;
        logic [ENTRIES-1:0][PA_W-1:0]   pa;
        logic [IDX_W-1:0]               ptr;
        logic [IDX_W-1:0]               widx;
        logic                           busy;
        logic                           done;
        span_t                          span;
        logic [REGIMES-1:0]             rmask;
    } state_t;

    state_t s_q, s_d;
    span_t  cmd_span;
    logic [ENTRIES-1:0] hit_vec;
    logic [SPAN_W-1:0]  walk_addr;
    logic               walk_in;

    range_tlb_decode u_dec (
        .operand  (inv_operand),
        .cfg_gran (cfg_gran),
        .cfg_ds   (cfg_ds),
        .span     (cmd_span)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_probe
        range_tlb_probe #(.RID_W(RID_W)) u_probe (
            .vld   (s_q.vld[g]),
            .tag   (s_q.tag[g]),
            .rid   (s_q.rid[g]),
            .q_tag (lk_va[VA_W-1:PG_LSB]),
            .q_rid (lk_regime),
            .hit   (hit_vec[g])
        );
    end

    always_comb begin
        lk_pa_page = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) lk_pa_page = s_q.pa[i];
        end
        lk_hit = (|hit_vec) && !s_q.busy;
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        walk_addr = {1'b0, s_q.tag[s_q.widx], {PG_LSB{1'b0}}};
        walk_in   = (walk_addr >= s_q.span.lo) && (walk_addr < s_q.span.hi);
        if (s_q.busy) begin
            if (s_q.vld[s_q.widx] && walk_in && s_q.rmask[s_q.rid[s_q.widx]])
                s_d.vld[s_q.widx] = 1'b0;
            s_d.widx = s_q.widx + 1'b1;
            if (s_q.widx == IDX_W'(ENTRIES - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else begin
            if (fill_en) begin
                s_d.vld[s_q.ptr] = 1'b1;
                s_d.tag[s_q.ptr] = fill_va_page;
                s_d.rid[s_q.ptr] = fill_regime;
                s_d.pa[s_q.ptr]  = fill_pa_page;
                s_d.ptr          = s_q.ptr + 1'b1;
            end
            if (inv_req) begin
                s_d.busy  = 1'b1;
                s_d.widx  = '0;
                s_d.span  = cmd_span;
                s_d.rmask = inv_regimes;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
endmodule

// File: rtl/range_tlb_checker.sv
module range_tlb_checker #(
    parameter int ENTRIES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic inv_req,
    input logic busy,
    input logic done,
    input logic lk_hit
);
    int unsigned walk_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) walk_cnt <= 0;
        else                 walk_cnt <= walk_cnt + 1;
    end

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !busy) |=> busy);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_walk_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (walk_cnt == ENTRIES));

    assert_no_hit_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lk_hit);
endmodule

bind range_tlb range_tlb_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .inv_req (inv_req),
    .busy    (busy),
    .done    (done),
    .lk_hit  (lk_hit)
);

// File: tb/sim_range_tlb.sv
module sim_range_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_gran = 2'd0;
    logic        cfg_ds = 1'b0;
    logic [63:0] lk_va = '0;
    logic [1:0]  lk_regime = '0;
    logic        lk_hit;
    logic [39:0] lk_pa_page;
    logic        fill_en = 1'b0;
    logic [51:0] fill_va_page = '0;
    logic [1:0]  fill_regime = '0;
    logic [39:0] fill_pa_page = '0;
    logic        inv_req = 1'b0;
    logic [63:0] inv_operand = '0;
    logic [3:0]  inv_regimes = '0;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [51:0] mtag [16];
    logic [1:0]  mrid [16];
    logic [39:0] mpa  [16];
    bit          mv   [16];
    int          mptr = 0;

    always #5 clk = ~clk;

    range_tlb u0 (.*);

    function automatic logic [63:0] mk_op(input logic [1:0] g, input logic [1:0] sc,
                                          input logic [4:0] n, input logic [36:0] b);
        return {16'h0, g, sc, n, 2'b00, b};
    endfunction

    function automatic void exp_span(input logic [63:0] op, input logic [1:0] cg, input bit ds,
                                     output logic [64:0] lo, output logic [64:0] hi);
        int ps;
        bit ok;
        logic [63:0] b;
        logic [64:0] len;
        ps = (op[47:46] == 2'd3) ? 16 : (op[47:46] == 2'd2) ? 14 : 12;
        ok = (op[47:46] != 2'd0) && (cg == op[47:46] - 2'd1);
        b  = {{27{op[36]}}, op[36:0]};
        lo = {1'b0, b << (ds ? 16 : ps)};
        len = ok ? ((65'(op[43:39]) + 65'd1) << (5 * int'(op[45:44]) + 1 + ps)) : 65'd0;
        hi = lo + len;
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [51:0] t, input logic [1:0] r, input logic [39:0] p);
        @(negedge clk);
        fill_en = 1'b1; fill_va_page = t; fill_regime = r; fill_pa_page = p;
        @(negedge clk);
        fill_en = 1'b0;
        mtag[mptr] = t; mrid[mptr] = r; mpa[mptr] = p; mv[mptr] = 1; mptr = (mptr + 1) % 16;
    endtask

    task automatic probe(input logic [51:0] t, input logic [1:0] r, input string req);
        bit eh = 0;
        logic [39:0] ep = '0;
        for (int i = 15; i >= 0; i--)
            if (mv[i] && mtag[i] == t && mrid[i] == r) begin eh = 1; ep = mpa[i]; end
        lk_va = {t, 12'h0}; lk_regime = r;
        #1;
        check(lk_hit == eh, req, "hit", 64'(lk_hit), 64'(eh));
        if (eh) check(lk_pa_page == ep, req, "pa", 64'(lk_pa_page), 64'(ep));
    endtask

    task automatic probe_all(input string req);
        @(negedge clk);
        for (int i = 0; i < 16; i++) probe(mtag[i], mrid[i], req);
    endtask

    task automatic model_inv(input logic [63:0] op, input logic [3:0] rm);
        logic [64:0] lo, hi, a;
        exp_span(op, cfg_gran, cfg_ds, lo, hi);
        for (int i = 0; i < 16; i++) begin
            a = {1'b0, mtag[i], 12'h0};
            if (mv[i] && a >= lo && a < hi && rm[mrid[i]]) mv[i] = 0;
        end
    endtask

    task automatic invalidate(input logic [63:0] op, input logic [3:0] rm);
        int n = 0;
        @(negedge clk);
        inv_req = 1'b1; inv_operand = op; inv_regimes = rm;
        @(negedge clk);
        inv_req = 1'b0;
        model_inv(op, rm);
        check(busy == 1'b1, "R9", "busy after accept", 64'(busy), 64'd1);
        while (!done && n < 40) begin @(negedge clk); n++; end
        check(n == 16 && !busy, "R9", "walk cycles", 64'(n), 64'd16);
    endtask

    task automatic wipe();
        for (int i = 0; i < 16; i++) fill(52'hA_0000_0000 + 52'(i), 2'd3, 40'(i));
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [64:0] lo, hi;
        logic [63:0] op;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 16; i++) begin mv[i] = 0; mtag[i] = '0; mrid[i] = '0; mpa[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1", "busy/done after reset", {62'd0, busy, done}, 64'd0);
        lk_va = 64'h0; lk_regime = 2'd0; #1;
        check(!lk_hit, "R1", "lookup after reset", 64'(lk_hit), 64'd0);

        // R2 fills and lookups, regime mismatch misses
        fill(52'h123, 2'd1, 40'h55);
        fill(52'h123, 2'd2, 40'h66);
        @(negedge clk);
        probe(52'h123, 2'd1, "R2");
        probe(52'h123, 2'd2, "R2");
        probe(52'h123, 2'd0, "R2");

        // R7 range edges at 4 KB: pages 0x100..0x107
        cfg_gran = 2'd0; cfg_ds = 1'b0;
        fill(52'hFF, 2'd0, 40'h1); fill(52'h100, 2'd0, 40'h2);
        fill(52'h107, 2'd0, 40'h3); fill(52'h108, 2'd0, 40'h4);
        invalidate(mk_op(2'd1, 2'd0, 5'd3, 37'h100), 4'b0001);
        @(negedge clk);
        lk_va = {52'hFF, 12'h0}; lk_regime = 0; #1;
        check(lk_hit, "R7", "page below base kept", 64'(lk_hit), 64'd1);
        lk_va = {52'h108, 12'h0}; #1;
        check(lk_hit, "R7", "page past end kept", 64'(lk_hit), 64'd1);
        lk_va = {52'h100, 12'h0}; #1;
        check(!lk_hit, "R7", "first page cleared", 64'(lk_hit), 64'd0);
        lk_va = {52'h107, 12'h0}; #1;
        check(!lk_hit, "R4", "last page cleared", 64'(lk_hit), 64'd0);

        // R3 granule mismatch changes nothing
        wipe();
        for (int i = 0; i < 16; i++) fill(52'h200 + 52'(i), 2'(i), 40'h100 + 40'(i));
        invalidate(mk_op(2'd2, 2'd3, 5'd31, 37'h0), 4'b1111);
        probe_all("R3");
        invalidate(mk_op(2'd0, 2'd3, 5'd31, 37'h0), 4'b1111);
        probe_all("R3");

        // R6 wide-address shift
        wipe();
        fill(52'h10, 2'd0, 40'h7); fill(52'h11, 2'd0, 40'h8);
        fill(52'h12, 2'd0, 40'h9); fill(52'h1, 2'd0, 40'hA);
        cfg_ds = 1'b1;
        invalidate(mk_op(2'd1, 2'd0, 5'd0, 37'h1), 4'b0001);
        probe_all("R6");
        cfg_ds = 1'b0;

        // R5 sign-extended base, 64 KB granule
        wipe();
        cfg_gran = 2'd2;
        fill(52'hF_FFFF_FFFF_FFF0, 2'd0, 40'h11);
        fill(52'hF_FFFF_FFFF_FFEF, 2'd0, 40'h12);
        fill(52'h0, 2'd0, 40'h13);
        invalidate(mk_op(2'd3, 2'd0, 5'd0, 37'h1F_FFFF_FFFF), 4'b0001);
        probe_all("R5");

        // R8 regime bitmap selects regimes 0 and 2
        wipe();
        cfg_gran = 2'd1;
        for (int r = 0; r < 4; r++) fill(52'h40, 2'(r), 40'h20 + 40'(r));
        invalidate(mk_op(2'd2, 2'd0, 5'd1, 37'h10), 4'b0101);
        probe_all("R8");

        // R9 / R10: fill, command and lookup during a walk
        wipe();
        cfg_gran = 2'd0;
        fill(52'h300, 2'd0, 40'h31); fill(52'h400, 2'd0, 40'h41);
        @(negedge clk);
        inv_req = 1'b1; inv_operand = mk_op(2'd1, 2'd0, 5'd0, 37'h300); inv_regimes = 4'b0001;
        @(negedge clk);
        inv_req = 1'b0;
        model_inv(mk_op(2'd1, 2'd0, 5'd0, 37'h300), 4'b0001);
        lk_va = {52'h400, 12'h0}; lk_regime = 0; #1;
        check(!lk_hit, "R10", "lookup stalled during walk", 64'(lk_hit), 64'd0);
        @(negedge clk);
        fill_en = 1'b1; fill_va_page = 52'h777; fill_regime = 0; fill_pa_page = 40'h77;
        inv_req = 1'b1; inv_operand = mk_op(2'd1, 2'd3, 5'd31, 37'h0); inv_regimes = 4'b1111;
        @(negedge clk);
        fill_en = 1'b0; inv_req = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(!busy, "R9", "second command dropped", 64'(busy), 64'd0);
        probe(52'h777, 2'd0, "R9");
        probe(52'h400, 2'd0, "R9");
        fill(52'h888, 2'd1, 40'h88);
        probe_all("R9");

        // randomized commands against the model
        for (int it = 0; it < 60; it++) begin
            logic [1:0] g;
            cfg_gran = 2'($urandom % 3);
            cfg_ds   = 1'($urandom % 2);
            g = (($urandom % 8) == 0) ? 2'($urandom % 4) : cfg_gran + 2'd1;
            op = mk_op(g, 2'($urandom), 5'($urandom), 37'({$urandom, $urandom}));
            exp_span(op, cfg_gran, cfg_ds, lo, hi);
            for (int e = 0; e < 16; e++) begin
                logic [51:0] t;
                case ($urandom % 3)
                    0: t = lo[63:12] - 52'd2 + 52'($urandom % 4);
                    1: t = hi[63:12] - 52'd2 + 52'($urandom % 4);
                    default: t = lo[63:12] + 52'($urandom % 64);
                endcase
                fill(t, 2'($urandom), 40'($urandom));
            end
            invalidate(op, 4'($urandom));
            probe_all("R4");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule